// File: doc/BRIEF.md
# Sixteen-Bit Timer with Selectable Clock Source

This block is a 16-bit up-counter kept as two byte registers and driven through a small byte-wide register bus. A control byte turns the timer on, chooses whether it advances on the internal instruction-cycle tick or on an external pin, picks how pin edges are qualified, and selects a power-of-two prescaler. A control bit also holds an oscillator-enable setting, but nothing acts on it.

When the counter wraps from its maximum value to zero, a one-cycle overflow pulse is raised. The full 16-bit count is always present on a parallel output, so a neighbouring capture/compare unit can sample it or match against it. A buffered access mode lets software read or load all sixteen bits as a unit, even though the bus carries only one byte at a time. A read of the low byte captures the matching high byte. A write of the high byte is held back until the low byte is written.

Top module: `tmr16_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) the count is 0x0000, the control byte reads 0x00 and ovf_flag is 0.
- R2: Register address 0 is the control byte, 1 the low count byte, 2 the high count byte and 3 is unused (reads 0x00, writes ignored). Control bit 0 = run, bit 1 = external source, bit 2 = unsynchronised pin counting, bit 3 = oscillator enable, bits 5:4 = prescale select, bit 6 = buffered 16-bit access. Bits 6:0 read back as written, and bit 7 reads 0.
- R3: With bit 1 clear, each cycle with cyc_tick high is a source event. With bit 0 clear, neither the count nor the prescaler advances.
- R4: Prescale select 0, 1, 2 and 3 gives one count per 1, 2, 4 and 8 source events. The prescaler restarts from zero on any write to the low or high byte.
- R5: With bits 1 and 2 set, a rising ext_clk seen at a clock edge (low at the previous edge) advances the count at that same edge.
- R6: With bit 1 set and bit 2 clear, ext_clk passes through two synchronising flops, so the count advances two clock edges later than in R5.
- R7: With bit 6 clear, a byte write replaces that byte of the count at once, and a high-byte read returns the live high byte.
- R8: With bit 6 set, a low-byte read captures the high byte, and later high-byte reads return that captured value.
- R9: With bit 6 set, a high-byte write leaves the count unchanged. The next low-byte write loads {buffered high, written low} in one step.
- R10: A counter step from 0xFFFF to 0x0000 raises ovf_flag for exactly the one cycle that follows the step. A byte write in the same cycle takes priority over the step.
- R11: count_val always equals the current 16-bit count, and the low-byte read matches count_val[7:0].
- R12: The oscillator-enable bit is stored and read back but has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_rd | input | 1 | Read strobe (needed for the buffered-read capture) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| cyc_tick | input | 1 | Internal instruction-cycle tick |
| ext_clk | input | 1 | External clock pin |
| ovf_flag | output | 1 | One-cycle overflow pulse |
| count_val | output | 16 | Current count, for a capture/compare unit |

## Verification
Directed sequences try each clock source on its own. Internal ticks with each prescale setting tell the divide ratios apart. Pin edges with and without synchronisation tell the zero-latency path from the two-flop path by the edge at which the count moves. Buffered reads and writes are placed around count changes, so a torn 16-bit access can be told from an atomic one, and a load of 0xFFFF followed by one tick shows the overflow timing. Random bus traffic, tick and pin activity, run against a cycle model in the bench, mixes mode changes with writes and wraps to expose ordering and priority faults.

// File: rtl/tmr16_pkg.sv
// Shared types for the 16-bit timer: register selects and control byte layout.
package tmr16_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_LOW  = 2'd1,
        REG_HIGH = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    // Control byte, bit 0 at the bottom.
    typedef struct packed {
        logic       spare;      // bit 7, always 0
        logic       buf16;      // bit 6, buffered 16-bit access
        logic [1:0] ps_sel;     // bits 5:4, prescale select
        logic       osc_keep;   // bit 3, stored only
        logic       async_cnt;  // bit 2, count pin without synchroniser
        logic       ext_src;    // bit 1, pin is the source
        logic       run;        // bit 0, timer enable
    } ctrl_t;
endpackage

// File: rtl/tmr16_clksrc.sv
// Source event selection for the timer.
// Picks the internal tick or a rising edge of the external pin. The pin edge is
// taken either straight from the pin (one history flop) or after a chain of
// SYNC_STAGES synchronising flops. Assumes the pin is slower than half the clock.
module tmr16_clksrc #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    input  logic cyc_tick,
    input  logic ext_src,
    input  logic async_cnt,
    output logic src_pulse
);
    logic [SYNC_STAGES-1:0] sync_sh;
    logic                   sync_prev;
    logic                   raw_prev;
    logic                   sync_edge;
    logic                   raw_edge;

    // Synchroniser chain plus edge-history flops for both pin paths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_sh   <= '0;
            sync_prev <= 1'b0;
            raw_prev  <= 1'b0;
        end else begin
            sync_sh   <= {sync_sh[SYNC_STAGES-2:0], ext_clk};
            sync_prev <= sync_sh[SYNC_STAGES-1];
            raw_prev  <= ext_clk;
        end
    end

    // Edge detection and source choice.
    always_comb begin
        sync_edge = sync_sh[SYNC_STAGES-1] & ~sync_prev;
        raw_edge  = ext_clk & ~raw_prev;
        if (!ext_src)
            src_pulse = cyc_tick;
        else if (async_cnt)
            src_pulse = raw_edge;
        else
            src_pulse = sync_edge;
    end

    AST_DIRECT_EDGE: assert property (@(posedge clk) disable iff (!rst_n) (ext_src && async_cnt && ext_clk && !$past(ext_clk)) |-> src_pulse) else $error("direct pin edge lost"); // R5
endmodule

// File: rtl/tmr16_presc.sv
// Power-of-two prescaler.
// Counts source events while the timer runs and issues an increment when the
// low ps_sel bits of its counter are all ones. Clearing restarts the division.
module tmr16_presc #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src_pulse,
    input  logic            run,
    input  logic [PS_W-1:0] ps_sel,
    input  logic            clr,
    output logic            inc
);
    localparam int CW = (1 << PS_W) - 1;

    logic [CW-1:0] ps_cnt;
    logic [CW-1:0] ps_mask;

    // Mask of the counter bits that must be set to finish one division.
    always_comb begin
        ps_mask = CW'((1 << ps_sel) - 1);
        inc     = run & src_pulse & ((ps_cnt & ps_mask) == ps_mask);
    end

    // Event counter, cleared by byte writes to the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ps_cnt <= '0;
        else if (clr)
            ps_cnt <= '0;
        else if (run && src_pulse)
            ps_cnt <= ps_cnt + 1'b1;
    end

    AST_PS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (ps_cnt == '0)) else $error("prescaler not cleared"); // R4
endmodule

// File: rtl/tmr16_timer.sv
// Sixteen-bit timer top.
// Holds the control byte, the count, the read and write high-byte buffers and
// the overflow pulse. The bus read is combinational; bus_rd only matters for
// the buffered-read capture. A count write wins over an increment in the same cycle.
module tmr16_timer
    import tmr16_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PS_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cyc_tick,
    input  logic              ext_clk,
    output logic              ovf_flag,
    output logic [2*BYTE_W-1:0] count_val
);
    localparam int CNT_W = 2 * BYTE_W;

    ctrl_t              ctrl_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [BYTE_W-1:0]  rd_hbuf;
    logic [BYTE_W-1:0]  wr_hbuf;
    logic               ovf_q;
    logic               src_pulse;
    logic               inc;
    reg_sel_e           sel;
    logic               ctrl_wr;
    logic               lo_wr;
    logic               hi_wr;
    logic               cnt_wr;
    logic               lo_rd;

    // Decode of the bus strobes.
    always_comb begin
        sel     = reg_sel_e'(bus_addr);
        ctrl_wr = bus_wr && (sel == REG_CTRL);
        lo_wr   = bus_wr && (sel == REG_LOW);
        hi_wr   = bus_wr && (sel == REG_HIGH);
        lo_rd   = bus_rd && (sel == REG_LOW);
        cnt_wr  = lo_wr || (hi_wr && !ctrl_q.buf16);
    end

    tmr16_clksrc #(.SYNC_STAGES(SYNC_STAGES)) i_clksrc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_clk   (ext_clk),
        .cyc_tick  (cyc_tick),
        .ext_src   (ctrl_q.ext_src),
        .async_cnt (ctrl_q.async_cnt),
        .src_pulse (src_pulse)
    );

    tmr16_presc #(.PS_W(PS_W)) i_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_pulse (src_pulse),
        .run       (ctrl_q.run),
        .ps_sel    (ctrl_q.ps_sel),
        .clr       (lo_wr || hi_wr),
        .inc       (inc)
    );

    // Control byte; the spare bit is forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= ctrl_t'({1'b0, bus_wdata[BYTE_W-2:0]});
    end

    // Count register: writes first, then increments.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (lo_wr)
            cnt_q <= ctrl_q.buf16 ? {wr_hbuf, bus_wdata} : {cnt_q[CNT_W-1:BYTE_W], bus_wdata};
        else if (hi_wr && !ctrl_q.buf16)
            cnt_q <= {bus_wdata, cnt_q[BYTE_W-1:0]};
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    // High-byte buffers for buffered 16-bit access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_hbuf <= '0;
            wr_hbuf <= '0;
        end else begin
            if (lo_rd && ctrl_q.buf16)
                rd_hbuf <= cnt_q[CNT_W-1:BYTE_W];
            if (hi_wr && ctrl_q.buf16)
                wr_hbuf <= bus_wdata;
        end
    end

    // One-cycle overflow pulse on a step from all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else
            ovf_q <= inc && !cnt_wr && (&cnt_q);
    end

    // Read data multiplexer.
    always_comb begin
        unique case (sel)
            REG_CTRL: bus_rdata = ctrl_q;
            REG_LOW:  bus_rdata = cnt_q[BYTE_W-1:0];
            REG_HIGH: bus_rdata = ctrl_q.buf16 ? rd_hbuf : cnt_q[CNT_W-1:BYTE_W];
            default:  bus_rdata = '0;
        endcase
    end

    assign ovf_flag  = ovf_q;
    assign count_val = cnt_q;

    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ovf_flag |=> !ovf_flag) else $error("overflow longer than one cycle"); // R10
    AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ovf_flag |-> (count_val == '0)) else $error("overflow without zero count"); // R10
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n) (!ctrl_q.run && !cnt_wr) |=> (cnt_q == $past(cnt_q))) else $error("count moved while stopped"); // R3
    AST_RD_LATCH: assert property (@(posedge clk) disable iff (!rst_n) (lo_rd && ctrl_q.buf16) |=> (rd_hbuf == $past(cnt_q[CNT_W-1:BYTE_W]))) else $error("high byte not captured"); // R8
endmodule

// File: tb/test_tmr16_timer.sv
// Bench for tmr16_timer: directed corner cases plus seeded random traffic,
// compared against a cycle model built from the requirements.
module test_tmr16_timer;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        cyc_tick = 1'b0;
    logic        ext_clk = 1'b0;
    logic        ovf_flag;
    logic [15:0] count_val;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    tmr16_timer i_tmr16_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cyc_tick(cyc_tick), .ext_clk(ext_clk), .ovf_flag(ovf_flag),
        .count_val(count_val)
    );

    // Reference model state.
    logic [6:0]  m_ctrl;
    logic [15:0] m_cnt;
    logic [7:0]  m_rhb, m_whb;
    logic        m_ovf;
    logic [2:0]  m_ps;
    logic        m_s1, m_s2, m_s3, m_rp;

    function automatic int div_of(input logic [1:0] sel);
        return 1 << sel;
    endfunction

    // Model next state from the requirements.
    always @(posedge clk) begin
        logic src, inc, lo, hi, cw;
        logic [2:0] mask;
        if (!rst_n) begin
            m_ctrl = '0; m_cnt = '0; m_rhb = '0; m_whb = '0; m_ovf = 0;
            m_ps = '0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_rp = 0;
        end else begin
            if (!m_ctrl[1]) src = cyc_tick;
            else if (m_ctrl[2]) src = ext_clk & ~m_rp;
            else src = m_s2 & ~m_s3;
            mask = 3'(div_of(m_ctrl[5:4]) - 1);
            inc  = m_ctrl[0] & src & ((m_ps & mask) == mask);
            lo   = bus_wr && bus_addr == 2'd1;
            hi   = bus_wr && bus_addr == 2'd2;
            cw   = lo | (hi & ~m_ctrl[6]);
            m_ovf = inc & ~cw & (m_cnt == 16'hFFFF);
            if (bus_rd && bus_addr == 2'd1 && m_ctrl[6]) m_rhb = m_cnt[15:8];
            if (lo) m_cnt = m_ctrl[6] ? {m_whb, bus_wdata} : {m_cnt[15:8], bus_wdata};
            else if (hi && !m_ctrl[6]) m_cnt = {bus_wdata, m_cnt[7:0]};
            else if (inc) m_cnt = m_cnt + 1;
            if (hi && m_ctrl[6]) m_whb = bus_wdata;
            if (lo | hi) m_ps = '0;
            else if (m_ctrl[0] & src) m_ps = m_ps + 1;
            if (bus_wr && bus_addr == 2'd0) m_ctrl = bus_wdata[6:0];
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk; m_rp = ext_clk;
        end
    end

    function automatic logic [7:0] exp_rdata();
        case (bus_addr)
            2'd0: return {1'b0, m_ctrl};
            2'd1: return m_cnt[7:0];
            2'd2: return m_ctrl[6] ? m_rhb : m_cnt[15:8];
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check read data, then outputs.
    task automatic step(input logic w, input logic r, input logic [1:0] a,
                        input logic [7:0] d, input logic t, input logic e, input string tag);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; cyc_tick = t; ext_clk = e;
        #1;
        if (r) check({tag, " rdata"}, 16'(bus_rdata), 16'(exp_rdata()));
        @(posedge clk); @(negedge clk);
        check({tag, " count"}, count_val, m_cnt);
        check({tag, " ovf"}, 16'(ovf_flag), 16'(m_ovf));
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        logic [15:0] base;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 count", count_val, 16'h0000);
        check("R1 ovf", 16'(ovf_flag), 16'h0000);
        step(0, 1, 2'd0, 8'h00, 0, 0, "R1");
        check("R1 ctrl", 16'(bus_rdata), 16'h0000);
        // R2 control layout, bit 7 reads 0; unused address
        step(1, 0, 2'd0, 8'hFF, 0, 0, "R2");
        step(0, 1, 2'd0, 8'h00, 0, 0, "R2");
        check("R2 ctrl readback", 16'(bus_rdata), 16'h007F);
        step(1, 0, 2'd3, 8'h55, 0, 0, "R2");
        step(0, 1, 2'd3, 8'h00, 0, 0, "R2");
        check("R2 unused", 16'(bus_rdata), 16'h0000);
        // R12 oscillator bit set, internal tick, divide by 1
        step(1, 0, 2'd0, 8'h09, 0, 0, "R12");
        repeat (5) step(0, 0, 2'd0, 8'h00, 1, 0, "R12");
        check("R12 count", count_val, 16'h0005);
        // R3 stopped timer ignores ticks
        step(1, 0, 2'd0, 8'h08, 0, 0, "R3");
        repeat (4) step(0, 0, 2'd0, 8'h00, 1, 0, "R3");
        check("R3 hold", count_val, 16'h0005);
        // R4 divide by 4, then prescaler clear
        step(1, 0, 2'd1, 8'h00, 0, 0, "R4");
        step(1, 0, 2'd0, 8'h21, 0, 0, "R4");
        repeat (8) step(0, 0, 2'd0, 8'h00, 1, 0, "R4");
        check("R4 div4", count_val, 16'h0002);
        repeat (3) step(0, 0, 2'd0, 8'h00, 1, 0, "R4");
        step(1, 0, 2'd1, 8'h10, 0, 0, "R4");
        repeat (3) step(0, 0, 2'd0, 8'h00, 1, 0, "R4");
        check("R4 cleared", count_val, 16'h0010);
        step(0, 0, 2'd0, 8'h00, 1, 0, "R4");
        check("R4 after clear", count_val, 16'h0011);
        // R5 direct pin edges
        step(1, 0, 2'd0, 8'h07, 0, 0, "R5");
        step(1, 0, 2'd1, 8'h00, 0, 0, "R5");
        step(0, 0, 2'd0, 8'h00, 0, 1, "R5");
        check("R5 first edge", count_val, 16'h0001);
        step(0, 0, 2'd0, 8'h00, 0, 1, "R5");
        step(0, 0, 2'd0, 8'h00, 0, 0, "R5");
        step(0, 0, 2'd0, 8'h00, 0, 1, "R5");
        check("R5 second edge", count_val, 16'h0002);
        // R6 synchronised pin, two extra edges of latency
        step(1, 0, 2'd0, 8'h03, 0, 0, "R6");
        repeat (4) step(0, 0, 2'd0, 8'h00, 0, 0, "R6");
        base = count_val;
        step(0, 0, 2'd0, 8'h00, 0, 1, "R6");
        check("R6 edge1", count_val, base);
        step(0, 0, 2'd0, 8'h00, 0, 1, "R6");
        check("R6 edge2", count_val, base);
        step(0, 0, 2'd0, 8'h00, 0, 1, "R6");
        check("R6 edge3", count_val, base + 16'd1);
        // R7 direct byte writes
        step(1, 0, 2'd0, 8'h00, 0, 0, "R7");
        step(1, 0, 2'd2, 8'h12, 0, 0, "R7");
        step(1, 0, 2'd1, 8'h34, 0, 0, "R7");
        check("R7 value", count_val, 16'h1234);
        step(0, 1, 2'd2, 8'h00, 0, 0, "R7");
        check("R7 live high", 16'(bus_rdata), 16'h0012);
        // R9 buffered write, R8 buffered read
        step(1, 0, 2'd0, 8'h41, 0, 0, "R9");
        step(1, 0, 2'd2, 8'h56, 0, 0, "R9");
        check("R9 held back", count_val, 16'h1234);
        step(1, 0, 2'd1, 8'hFF, 0, 0, "R9");
        check("R9 commit", count_val, 16'h56FF);
        step(0, 1, 2'd1, 8'h00, 1, 0, "R8");
        check("R8 count moved", count_val, 16'h5700);
        step(0, 1, 2'd2, 8'h00, 0, 0, "R8");
        check("R8 latched high", 16'(bus_rdata), 16'h0056);
        // R10 wrap
        step(1, 0, 2'd0, 8'h01, 0, 0, "R10");
        step(1, 0, 2'd2, 8'hFF, 0, 0, "R10");
        step(1, 0, 2'd1, 8'hFF, 0, 0, "R10");
        step(0, 0, 2'd0, 8'h00, 1, 0, "R10");
        check("R10 wrap count", count_val, 16'h0000);
        check("R10 ovf set", 16'(ovf_flag), 16'h0001);
        step(0, 0, 2'd0, 8'h00, 0, 0, "R10");
        check("R10 ovf cleared", 16'(ovf_flag), 16'h0000);
        // R11 and all others: random traffic against the model
        for (int i = 0; i < 6000; i++) begin
            logic w, r, t, e;
            logic [1:0] a;
            logic [7:0] d;
            w = ($urandom % 12) == 0;
            r = ($urandom % 4) == 0;
            a = 2'($urandom % 4);
            d = (($urandom % 3) == 0) ? 8'hFF : 8'($urandom);
            if (w && a == 2'd0) d = d | 8'h01;
            t = $urandom % 2;
            e = (($urandom % 3) == 0) ? ~ext_clk : ext_clk;
            step(w, r, a, d, t, e, "R11 random");
        end
        summary();
    end
endmodule